// File: doc/BRIEF.md
# Level-Sensitive Interrupt Controller

This block gathers a set of level-sensitive interrupt lines, grouped in banks of 32, and presents them to one processor through a single request output. Each source can be enabled or disabled through write-one-to-set and write-one-to-clear aliases of its bank's mask, and software can read the unmasked pending lines of a bank. An arbiter picks the pending source with the lowest priority value. That source is latched as the active interrupt and held there until software writes an acknowledge.

Software reaches the block over a simple 32-bit register bus with byte addresses inside a 4 KB window. Writes take effect at the clock edge and reads return the value in the same cycle. A self-clearing soft reset returns every register to its default state and reports its progress through a done flag. The configuration word also holds an autoidle enable, and three further words are plain read/write storage, so that their contents can be saved and restored. The bank count is a build-time parameter: three banks (96 sources) by default, and up to four (128 sources).

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After hardware reset every source is masked (each bank mask reads 0xFFFFFFFF), `irq_req` is low, the active-number word at 0x040 reads 0 and the reset-done flag (bit 0 of 0x014) reads 1.
- R2: A write to a bank's enable alias (0x088 + 0x20*b) clears the mask bit of every source whose data bit is 1. Bits written as 0 leave their mask bits unchanged.
- R3: A write to a bank's disable alias (0x08C + 0x20*b) sets the mask bit of every source whose data bit is 1. Bits written as 0 leave their mask bits unchanged.
- R4: The pending word of bank b (0x098 + 0x20*b) reads the input levels of that bank ANDed with the inverse of its mask.
- R5: When no interrupt is active and some source is pending, the next clock edge latches as active the pending source with the lowest priority value. A tie goes to the lowest source number.
- R6: While a source is active, `irq_req` is high and the active number stays unchanged until an acknowledge, even when sources are masked, raised or dropped.
- R7: Writing 1 to bit 0 of 0x048 acknowledges. At that edge the block latches the winner among the sources pending in that same cycle. If none is pending, `irq_req` falls and the active number reads 0.
- R8: Writing 1 to bit 1 of the configuration word (0x010) starts a soft reset. From the next edge the done flag reads 0 for RST_CYC cycles, and bus writes are ignored during that time. Afterwards the flag reads 1 again, bit 1 reads 0, and every register holds the value it has after hardware reset.
- R9: Bit 0 of 0x010 is a read/write autoidle enable. The words at 0x04C, 0x050 and 0x068 are 32-bit read/write storage that resets to 0.
- R10: The word at 0x000 returns the 8-bit parameter REV in bits [7:0] (major version in [7:4], minor in [3:0]), with the upper bits 0.
- R11: Source n has a level word at 0x100 + 4*n. Bits [7:2] hold its priority and read back as written, while bits [1:0] and [31:8] read 0.
- R12: A write to a bank's mask word (0x084 + 0x20*b) loads the whole mask directly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle |
| irq_in | input | NBANK*32 | Level interrupt inputs |
| irq_req | output | 1 | Interrupt request to the processor |

## Verification
The acknowledge and the arrival of a new source can fall in the same clock cycle. This matters because the selection made at the acknowledge edge must already see the newly arriving line. The bench lets one source sit active, then raises a line that has a better priority and was unmasked earlier in the very cycle that carries the acknowledge write. It expects that line's number as the new active source, with `irq_req` never dropping. Freezing is judged by masking the active source without an acknowledge and checking that the active number does not move.

// File: rtl/lic_pkg.sv
package lic_pkg;
  localparam int BANK_W = 32;
  localparam int ID_W   = 7;

  localparam logic [11:0] A_REV    = 12'h000;
  localparam logic [11:0] A_CFG    = 12'h010;
  localparam logic [11:0] A_STAT   = 12'h014;
  localparam logic [11:0] A_ACTIVE = 12'h040;
  localparam logic [11:0] A_ACK    = 12'h048;
  localparam logic [11:0] A_PROT   = 12'h04C;
  localparam logic [11:0] A_IDLE   = 12'h050;
  localparam logic [11:0] A_THR    = 12'h068;
  localparam logic [11:0] A_LVL0   = 12'h100;

  // offsets inside one bank block (bank block starts at 0x80 + 0x20*b)
  localparam logic [4:0] O_MASK = 5'h04;
  localparam logic [4:0] O_CLR  = 5'h08;
  localparam logic [4:0] O_SET  = 5'h0C;
  localparam logic [4:0] O_PEND = 5'h18;

  // apply enable (clear) and disable (set) aliases to a mask word
  function automatic logic [BANK_W-1:0] mask_update(
    input logic [BANK_W-1:0] cur,
    input logic [BANK_W-1:0] clr_bits,
    input logic [BANK_W-1:0] set_bits);
    return (cur & ~clr_bits) | set_bits;
  endfunction

  // strict priority comparison: a lower value wins
  function automatic logic prio_beats(input logic [5:0] cand, input logic [5:0] best);
    return cand < best;
  endfunction
endpackage

// File: rtl/lic_mask_bank.sv
module lic_mask_bank
  import lic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_clr,
  input  logic              wr_mask,
  input  logic              wr_clr,
  input  logic              wr_set,
  input  logic [BANK_W-1:0] wdata,
  input  logic [BANK_W-1:0] lines,
  output logic [BANK_W-1:0] mask,
  output logic [BANK_W-1:0] pend
);
  logic [BANK_W-1:0] clr_bits, set_bits;

  assign clr_bits = wr_clr ? wdata : '0;
  assign set_bits = wr_set ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mask <= '1;
    else if (soft_clr) mask <= '1;
    else if (wr_mask)  mask <= wdata;
    else               mask <= mask_update(mask, clr_bits, set_bits);
  end

  assign pend = lines & ~mask;

  p_clr_unmasks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && !soft_clr) |=> ((mask & $past(wdata)) == '0));
  p_clr_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && !soft_clr) |=> ((mask & ~$past(wdata)) == ($past(mask) & ~$past(wdata))));
  p_set_masks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_set && !soft_clr) |=> ((mask & $past(wdata)) == $past(wdata)));
  p_set_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_set && !soft_clr) |=> ((mask & ~$past(wdata)) == ($past(mask) & ~$past(wdata))));
endmodule

// File: rtl/lic_arbiter.sv
module lic_arbiter
  import lic_pkg::*;
#(
  parameter int NSRC   = 96,
  parameter int PRIO_W = 6
)(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NSRC-1:0]                pend,
  input  logic [NSRC-1:0][PRIO_W-1:0]    prio,
  output logic                           any,
  output logic [ID_W-1:0]                win
);
  logic [PRIO_W-1:0] best;

  always_comb begin
    any  = 1'b0;
    best = '1;
    win  = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (pend[i] && (!any || prio_beats(prio[i], best))) begin
        any  = 1'b1;
        best = prio[i];
        win  = ID_W'(i);
      end
    end
  end

  p_winner_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> pend[win]);
  p_none_when_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> !any);
endmodule

// File: rtl/lic_active.sv
module lic_active
  import lic_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_clr,
  input  logic            ack,
  input  logic            any,
  input  logic [ID_W-1:0] win,
  output logic            act_valid,
  output logic [ID_W-1:0] act_num
);
  logic take;

  // a new selection happens when idle or at an acknowledge
  assign take = !act_valid || ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_valid <= 1'b0;
      act_num   <= '0;
    end else if (soft_clr) begin
      act_valid <= 1'b0;
      act_num   <= '0;
    end else if (take) begin
      act_valid <= any;
      act_num   <= any ? win : '0;
    end
  end

  p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && !ack && !soft_clr) |=> (act_valid && $stable(act_num)));
  p_ack_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !any && !soft_clr) |=> (!act_valid && act_num == '0));
  p_ack_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && any && !soft_clr) |=> (act_valid && act_num == $past(win)));
endmodule

// File: rtl/lic_sysctl.sv
module lic_sysctl #(
  parameter int RST_CYC = 4
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_cfg,
  input  logic        wr_prot,
  input  logic        wr_idle,
  input  logic        wr_thr,
  input  logic [31:0] wdata,
  output logic        soft_clr,
  output logic        done,
  output logic        autoidle,
  output logic [31:0] prot,
  output logic [31:0] idle,
  output logic [31:0] thr
);
  localparam int CW = $clog2(RST_CYC + 1);

  logic [CW-1:0] cnt;
  logic          start;

  assign start    = wr_cfg && wdata[1];
  assign soft_clr = (cnt != '0);
  assign done     = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (start)    cnt <= CW'(RST_CYC);
    else if (soft_clr) cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || soft_clr) begin
      autoidle <= 1'b0;
      prot     <= '0;
      idle     <= '0;
      thr      <= '0;
    end else begin
      if (wr_cfg && !start) autoidle <= wdata[0];
      else if (start)       autoidle <= 1'b0;
      if (wr_prot) prot <= wdata;
      if (wr_idle) idle <= wdata;
      if (wr_thr)  thr  <= wdata;
    end
  end

  p_start_drops_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done);
  p_done_sticks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
  p_clear_storage_r8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (prot == '0 && thr == '0 && !autoidle));
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import lic_pkg::*;
#(
  parameter int          NBANK   = 3,
  parameter int          PRIO_W  = 6,
  parameter int          RST_CYC = 4,
  parameter logic [7:0]  REV     = 8'h21
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_sel,
  input  logic                    bus_wr,
  input  logic [11:0]             bus_addr,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  input  logic [NBANK*BANK_W-1:0] irq_in,
  output logic                    irq_req
);
  localparam int NSRC = NBANK * BANK_W;

  logic soft_clr, done, autoidle;
  logic [31:0] prot_q, idle_q, thr_q;
  logic wr_en;
  logic in_bank, in_lvl;
  logic [1:0]  bidx;
  logic [4:0]  sub;
  logic [11:0] loff;
  logic [9:0]  lidx;

  logic [NBANK-1:0][BANK_W-1:0] mask_q, pend_q;
  logic [NSRC-1:0]              pend_flat;
  logic [NSRC-1:0][PRIO_W-1:0]  lvl_q;

  logic            any_pend;
  logic [ID_W-1:0] win_id;
  logic            act_valid;
  logic [ID_W-1:0] act_num;
  logic            ack;

  // ---------------- address decode ----------------
  assign wr_en   = bus_sel && bus_wr && !soft_clr;
  assign bidx    = bus_addr[6:5];
  assign sub     = bus_addr[4:0];
  assign in_bank = (bus_addr[11:8] == 4'h0) && bus_addr[7] && (int'(bidx) < NBANK);
  assign loff    = bus_addr - A_LVL0;
  assign lidx    = loff[11:2];
  assign in_lvl  = (bus_addr[11:8] != 4'h0) && (int'(lidx) < NSRC);
  assign ack     = wr_en && (bus_addr == A_ACK) && bus_wdata[0];

  // ---------------- mask banks ----------------
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit;
    assign hit = wr_en && in_bank && (bidx == 2'(b));
    lic_mask_bank u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_clr (soft_clr),
      .wr_mask  (hit && sub == O_MASK),
      .wr_clr   (hit && sub == O_CLR),
      .wr_set   (hit && sub == O_SET),
      .wdata    (bus_wdata),
      .lines    (irq_in[b*BANK_W +: BANK_W]),
      .mask     (mask_q[b]),
      .pend     (pend_q[b])
    );
    assign pend_flat[b*BANK_W +: BANK_W] = pend_q[b];
  end

  // ---------------- per-source level words ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lvl_q <= '0;
    else if (soft_clr) lvl_q <= '0;
    else if (wr_en && in_lvl) lvl_q[lidx[ID_W-1:0]] <= bus_wdata[PRIO_W+1:2];
  end

  // ---------------- selection and latch ----------------
  lic_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .pend  (pend_flat),
    .prio  (lvl_q),
    .any   (any_pend),
    .win   (win_id)
  );

  lic_active u_act (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_clr  (soft_clr),
    .ack       (ack),
    .any       (any_pend),
    .win       (win_id),
    .act_valid (act_valid),
    .act_num   (act_num)
  );

  assign irq_req = act_valid;

  // ---------------- system control ----------------
  lic_sysctl #(.RST_CYC(RST_CYC)) u_sys (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_cfg   (wr_en && bus_addr == A_CFG),
    .wr_prot  (wr_en && bus_addr == A_PROT),
    .wr_idle  (wr_en && bus_addr == A_IDLE),
    .wr_thr   (wr_en && bus_addr == A_THR),
    .wdata    (bus_wdata),
    .soft_clr (soft_clr),
    .done     (done),
    .autoidle (autoidle),
    .prot     (prot_q),
    .idle     (idle_q),
    .thr      (thr_q)
  );

  // ---------------- read mux ----------------
  always_comb begin
    bus_rdata = '0;
    if (in_bank) begin
      case (sub)
        O_MASK:  bus_rdata = mask_q[bidx];
        O_PEND:  bus_rdata = pend_q[bidx];
        default: bus_rdata = '0;
      endcase
    end else if (in_lvl) begin
      bus_rdata = 32'({lvl_q[lidx[ID_W-1:0]], 2'b00});
    end else begin
      case (bus_addr)
        A_REV:    bus_rdata = {24'h0, REV};
        A_CFG:    bus_rdata = {31'h0, autoidle};
        A_STAT:   bus_rdata = {31'h0, done};
        A_ACTIVE: bus_rdata = {25'h0, act_num};
        A_PROT:   bus_rdata = prot_q;
        A_IDLE:   bus_rdata = idle_q;
        A_THR:    bus_rdata = thr_q;
        default:  bus_rdata = '0;
      endcase
    end
  end

  p_req_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !ack && !soft_clr) |=> irq_req);
  p_write_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (mask_q == '1));
endmodule

// File: tb/lvl_irq_ctrl_test.sv
module lvl_irq_ctrl_test;
  localparam int NB  = 3;
  localparam int NS  = NB * 32;
  localparam int RC  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NS-1:0] irq_in = '0;
  logic irq_req;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  lvl_irq_ctrl #(.NBANK(NB), .RST_CYC(RC), .REV(8'h21)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_in(irq_in), .irq_req(irq_req));

  function automatic logic [11:0] bank_addr(input int b, input int off);
    return 12'(32'h80 + 32 * b + off);
  endfunction

  function automatic logic [11:0] lvl_addr(input int n);
    return 12'(32'h100 + 4 * n);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic quiet_all();
    for (int b = 0; b < NB; b++) wr(bank_addr(b, 'h0C), 32'hFFFF_FFFF);
    irq_in = '0;
    wr(12'h048, 32'h1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int b = 0; b < NB; b++) begin
      rd(bank_addr(b, 'h04), v); check("R1 mask after reset", v, 32'hFFFF_FFFF);
    end
    rd(12'h040, v); check("R1 active after reset", v, 0);
    check("R1 irq_req after reset", {31'h0, irq_req}, 0);
    rd(12'h014, v); check("R1 done after reset", v, 1);
    rd(12'h000, v); check("R10 revision", v, 32'h21);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    logic [31:0] pat;
    pat = 32'hA5C3_F0F1;
    wr(bank_addr(1, 'h08), 32'h0000_F00F);
    rd(bank_addr(1, 'h04), v); check("R2 enable alias", v, 32'hFFFF_0FF0);
    wr(bank_addr(1, 'h0C), 32'h0000_0003);
    rd(bank_addr(1, 'h04), v); check("R3 disable alias", v, 32'hFFFF_0FF3);
    wr(bank_addr(1, 'h08), 32'h0);
    rd(bank_addr(1, 'h04), v); check("R2 zero write no effect", v, 32'hFFFF_0FF3);
    wr(bank_addr(1, 'h0C), 32'h0);
    rd(bank_addr(1, 'h04), v); check("R3 zero write no effect", v, 32'hFFFF_0FF3);
    @(negedge clk); irq_in[63:32] = pat;
    rd(bank_addr(1, 'h18), v); check("R4 pending bank1", v, pat & ~32'hFFFF_0FF3);
    rd(bank_addr(0, 'h18), v); check("R4 pending bank0 masked", v, 0);
    wr(bank_addr(0, 'h04), 32'h1234_5678);
    rd(bank_addr(0, 'h04), v); check("R12 direct mask load", v, 32'h1234_5678);
    quiet_all();
    check("R7 idle after cleanup", {31'h0, irq_req}, 0);
  endtask

  task automatic t_level();
    logic [31:0] v;
    wr(lvl_addr(70), 32'hFFFF_FFFF);
    rd(lvl_addr(70), v); check("R11 level readback", v, 32'hFC);
    wr(lvl_addr(70), 32'h0);
  endtask

  task automatic t_arb();
    logic [31:0] v;
    wr(lvl_addr(10), 32'(20 << 2));
    wr(lvl_addr(40), 32'(5 << 2));
    wr(lvl_addr(70), 32'(5 << 2));
    wr(bank_addr(0, 'h08), 32'h1 << 10);
    wr(bank_addr(1, 'h08), 32'h1 << 8);
    wr(bank_addr(2, 'h08), 32'h1 << 6);
    @(negedge clk);
    irq_in[10] = 1'b1; irq_in[40] = 1'b1; irq_in[70] = 1'b1;
    @(negedge clk);
    rd(12'h040, v); check("R5 tie goes to lower number", v, 40);
    check("R6 request high while active", {31'h0, irq_req}, 1);
    wr(bank_addr(1, 'h0C), 32'h1 << 8);
    @(negedge clk);
    rd(12'h040, v); check("R6 frozen while masked", v, 40);
    wr(12'h048, 32'h1);
    rd(12'h040, v); check("R7 ack selects next", v, 70);
    wr(bank_addr(2, 'h0C), 32'h1 << 6);
    wr(12'h048, 32'h1);
    rd(12'h040, v); check("R5 remaining lowest prio", v, 10);
    wr(bank_addr(0, 'h0C), 32'h1 << 10);
    wr(12'h048, 32'h1);
    rd(12'h040, v); check("R7 ack empty reads 0", v, 0);
    check("R7 request drops", {31'h0, irq_req}, 0);
    irq_in = '0;
  endtask

  task automatic t_same_cycle();
    logic [31:0] v;
    wr(lvl_addr(5), 32'(10 << 2));
    wr(lvl_addr(90), 32'(2 << 2));
    wr(bank_addr(0, 'h08), 32'h1 << 5);
    wr(bank_addr(2, 'h08), 32'h1 << 26);
    @(negedge clk); irq_in[5] = 1'b1;
    @(negedge clk);
    rd(12'h040, v); check("R5 single source", v, 5);
    @(negedge clk);
    irq_in[90] = 1'b1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'h048; bus_wdata = 32'h1;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    rd(12'h040, v); check("R7 arrival in ack cycle", v, 90);
    check("R6 request stays high", {31'h0, irq_req}, 1);
    quiet_all();
    wr(lvl_addr(5), 0); wr(lvl_addr(90), 0);
  endtask

  task automatic t_srst();
    logic [31:0] v;
    wr(12'h04C, 32'h55); wr(12'h050, 32'h3); wr(12'h068, 32'h7F);
    wr(12'h010, 32'h1);
    rd(12'h04C, v); check("R9 protection storage", v, 32'h55);
    rd(12'h050, v); check("R9 idle storage", v, 32'h3);
    rd(12'h068, v); check("R9 threshold storage", v, 32'h7F);
    rd(12'h010, v); check("R9 autoidle set", v, 1);
    wr(lvl_addr(3), 32'h10);
    wr(bank_addr(0, 'h08), 32'h8);
    @(negedge clk); irq_in[3] = 1'b1;
    @(negedge clk);
    check("R6 request before soft reset", {31'h0, irq_req}, 1);
    wr(12'h010, 32'h2);
    rd(12'h014, v); check("R8 done low during reset", v, 0);
    wr(12'h068, 32'h11);
    repeat (RC + 2) @(negedge clk);
    rd(12'h014, v); check("R8 done back high", v, 1);
    rd(12'h010, v); check("R8 config cleared", v, 0);
    rd(12'h068, v); check("R8 write ignored and storage cleared", v, 0);
    rd(12'h04C, v); check("R8 protection cleared", v, 0);
    rd(bank_addr(0, 'h04), v); check("R8 mask restored", v, 32'hFFFF_FFFF);
    rd(lvl_addr(3), v); check("R8 level cleared", v, 0);
    rd(12'h040, v); check("R8 active cleared", v, 0);
    check("R8 request low", {31'h0, irq_req}, 0);
    irq_in = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask();
    t_level();
    t_arb();
    t_same_cycle();
    t_srst();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule